// File: doc/BRIEF.md
# Programmable Three-Table Logic Cell

This cell is a small piece of programmable combinational logic. It has two 16-entry lookup tables, each driven by its own four input lines. A third, 8-entry table combines their results. Each of the third table's three address bits has a configuration selector in front of it. Two of these bits can take either a first-level table result or one of three control lines. The third bit always takes one of the control lines. With these selectors the cell can be set up as three independent functions. It can also be set up as one function of five inputs, or as wider functions that split into smaller parts.

All table contents and selector settings sit in a single shift register. The register is loaded one bit per clock while the program enable is high. All three outputs stay at 0 while loading is in progress. Once the enable drops, the register holds its contents. From then on the outputs depend only on the data inputs and the stored configuration, with no clocked stage in the data path.

Top module: `lut_cell`

## Requirements
- R1: After an active-low reset, every table bit and selector bit is 0, so all three outputs read 0 for any data input.
- R2: While `prog_en_i` is high, each rising clock edge shifts `cfg_bit_i` into the top of a 48-bit register, and the existing contents move one place toward bit 0. After 48 shifts, the first bit sent lands at bit 0. The bit layout, from bit 0 upward, is:
  - F table entries 0..15 at bits 0..15
  - G table entries 0..15 at bits 16..31
  - H table entries 0..7 at bits 32..39
  - `a_src` at bit 40
  - `b_src` at bit 41
  - `a_line` at bits 43:42
  - `b_line` at bits 45:44
  - `e_line` at bits 47:46
- R3: `x_o` equals F table entry `f_in_i`, where `f_in_i[0]` is the address LSB.
- R4: `z_o` equals G table entry `g_in_i`, where `g_in_i[0]` is the address LSB.
- R5: `y_o` equals H table entry {e, b, a}, with a as the LSB. When `a_src`=0, a is `x_o`. When `b_src`=0, b is `z_o`.
- R6: When `a_src`=1, a is the control line picked by `a_line`. The line codes are 0 for `c_in_i[0]`, 1 for `c_in_i[1]`, 2 for `c_in_i[2]`, and 3 falls back to `c_in_i[0]`.
- R7: When `b_src`=1, b is the control line picked by `b_line`, using the same line codes as R6.
- R8: e is always the control line picked by `e_line`, using the same line codes as R6.
- R9: While `prog_en_i` is high, `x_o`, `y_o` and `z_o` are all 0.
- R10: While `prog_en_i` is low, `cfg_bit_i` has no effect and the stored configuration does not change.
- R11: Set up as follows, `y_o` equals any chosen 5-input function of {`c_in_i[0]`, A4..A1}:
  - G holds the cofactor for `c_in_i[0]`=0 and F holds the cofactor for `c_in_i[0]`=1.
  - F and G are both addressed by A4..A1.
  - `a_src`=`b_src`=0 and `e_line`=0.
  - H holds the 2:1 select pattern 8'hAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_en_i | input | 1 | Program enable: shift configuration and force the outputs low |
| cfg_bit_i | input | 1 | Serial configuration data |
| f_in_i | input | 4 | F table address |
| g_in_i | input | 4 | G table address |
| c_in_i | input | 3 | Control lines for the H selectors |
| x_o | output | 1 | F table result |
| y_o | output | 1 | H table result |
| z_o | output | 1 | G table result |

## Verification
The assertions check several rules on every cycle:
- the serial shift step while loading;
- that the configuration holds while the enable is low;
- that the outputs are forced to 0 during loading;
- the F lookup, and the H lookup when both of its result paths take the first-level outputs.

Other behaviour shows only in the bench's scenarios, because it depends on a whole 48-bit load landing in the right fields:
- the placement of fields in the chain;
- every code of the line selectors, including the fallback code;
- the composition of a full 5-input function from two cofactors.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int FK    = 4;
  localparam int HK    = 3;
  localparam int NLINE = 3;
  localparam int SELW  = 2;
  localparam int F_SZ  = 1 << FK;
  localparam int H_SZ  = 1 << HK;
  localparam int CFG_W = 2 * F_SZ + H_SZ + 2 + 3 * SELW;

  // first member is most significant: f_tab sits at bit 0
  typedef struct packed {
    logic [SELW-1:0] e_line;
    logic [SELW-1:0] b_line;
    logic [SELW-1:0] a_line;
    logic            b_src;
    logic            a_src;
    logic [H_SZ-1:0] h_tab;
    logic [F_SZ-1:0] g_tab;
    logic [F_SZ-1:0] f_tab;
  } cfg_t;
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= {bit_i, q[W-1:1]};
  end

  assign q_o = q;
endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tab_i,
  input  logic [K-1:0] addr_i,
  output logic         out_o
);
  assign out_o = tab_i[addr_i];
endmodule

// File: rtl/lut_line_sel.sv
module lut_line_sel #(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic [SW-1:0] sel_i,
  input  logic [N-1:0]  lines_i,
  output logic          out_o
);
  always_comb begin
    out_o = lines_i[0];  // undefined codes fall back to line 0
    for (int i = 1; i < N; i++)
      if (int'(sel_i) == i) out_o = lines_i[i];
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic             cfg_bit_i,
  input  logic [FK-1:0]    f_in_i,
  input  logic [FK-1:0]    g_in_i,
  input  logic [NLINE-1:0] c_in_i,
  output logic             x_o,
  output logic             y_o,
  output logic             z_o
);
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic [1:0]       l1_out;
  logic [2:0]       line_out;
  logic [HK-1:0]    h_addr;
  logic             h_out;

  lut_cfg_chain #(.W(CFG_W)) chain_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (prog_en_i),
    .bit_i (cfg_bit_i),
    .q_o   (cfg_q)
  );

  assign cfg = cfg_t'(cfg_q);

  // first-level tables: 0 = F, 1 = G
  for (genvar t = 0; t < 2; t++) begin : g_l1
    lut_table #(.K(FK)) tab_i (
      .tab_i (t == 0 ? cfg.f_tab : cfg.g_tab),
      .addr_i(t == 0 ? f_in_i : g_in_i),
      .out_o (l1_out[t])
    );
  end

  // line selectors: 0 = a path, 1 = b path, 2 = e input
  for (genvar s = 0; s < 3; s++) begin : g_sel
    lut_line_sel #(.N(NLINE), .SW(SELW)) sel_i (
      .sel_i  (s == 0 ? cfg.a_line : (s == 1 ? cfg.b_line : cfg.e_line)),
      .lines_i(c_in_i),
      .out_o  (line_out[s])
    );
  end

  assign h_addr[0] = cfg.a_src ? line_out[0] : l1_out[0];
  assign h_addr[1] = cfg.b_src ? line_out[1] : l1_out[1];
  assign h_addr[2] = line_out[2];

  lut_table #(.K(HK)) h_tab_i (
    .tab_i (cfg.h_tab),
    .addr_i(h_addr),
    .out_o (h_out)
  );

  assign x_o = !prog_en_i && l1_out[0];
  assign z_o = !prog_en_i && l1_out[1];
  assign y_o = !prog_en_i && h_out;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prog_en_i,
  input logic             cfg_bit_i,
  input logic [FK-1:0]    f_in_i,
  input logic [NLINE-1:0] c_in_i,
  input logic             x_o,
  input logic             y_o,
  input logic             z_o,
  input logic [CFG_W-1:0] cfg_q
);
  cfg_t cv;
  logic e_bit;
  assign cv    = cfg_t'(cfg_q);
  assign e_bit = (cv.e_line == 2'd1) ? c_in_i[1] :
                 (cv.e_line == 2'd2) ? c_in_i[2] : c_in_i[0];

  // R2
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |=> (cfg_q[CFG_W-1] == $past(cfg_bit_i)) &&
                  (cfg_q[CFG_W-2:0] == $past(cfg_q[CFG_W-1:1])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |=> $stable(cfg_q));

  // R9
  prog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |-> !(x_o || y_o || z_o));

  // R3
  f_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |-> x_o == cv.f_tab[f_in_i]);

  // R5
  h_compose_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && !cv.a_src && !cv.b_src) |-> y_o == cv.h_tab[{e_bit, z_o, x_o}]);
endmodule

bind lut_cell lut_cell_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .prog_en_i(prog_en_i),
  .cfg_bit_i(cfg_bit_i),
  .f_in_i   (f_in_i),
  .c_in_i   (c_in_i),
  .x_o      (x_o),
  .y_o      (y_o),
  .z_o      (z_o),
  .cfg_q    (cfg_q)
);

// File: tb/lut_cell_tb_top.sv
module lut_cell_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_en_i = 1'b0;
  logic       cfg_bit_i = 1'b0;
  logic [3:0] f_in_i = '0;
  logic [3:0] g_in_i = '0;
  logic [2:0] c_in_i = '0;
  logic       x_o, y_o, z_o;

  always #5 clk_i = ~clk_i;

  lut_cell dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_en_i(prog_en_i), .cfg_bit_i(cfg_bit_i),
    .f_in_i(f_in_i), .g_in_i(g_in_i), .c_in_i(c_in_i),
    .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  typedef struct {
    logic [2:0] exp;  // {x, y, z}
    string      req;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [47:0] cur_cfg;

  function automatic logic pick(logic [1:0] s, logic [2:0] c);
    case (s)
      2'd1:    return c[1];
      2'd2:    return c[2];
      default: return c[0];
    endcase
  endfunction

  function automatic logic [47:0] mk_cfg(logic [15:0] f, logic [15:0] g, logic [7:0] h,
                                         logic ma, logic mb, logic [1:0] mc,
                                         logic [1:0] md, logic [1:0] me);
    return {me, md, mc, mb, ma, h, g, f};
  endfunction

  function automatic logic [2:0] model(logic [47:0] w, logic [3:0] f, logic [3:0] g,
                                       logic [2:0] c);
    logic x, z, a, b, e;
    x = w[f];
    z = w[16 + int'(g)];
    a = w[40] ? pick(w[43:42], c) : x;
    b = w[41] ? pick(w[45:44], c) : z;
    e = pick(w[47:46], c);
    return {x, w[32 + int'({e, b, a})], z};
  endfunction

  task automatic load(logic [47:0] w);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk_i);
      prog_en_i = 1'b1;
      cfg_bit_i = w[i];
    end
    @(negedge clk_i);
    prog_en_i = 1'b0;
    cfg_bit_i = 1'b0;
    cur_cfg   = w;
  endtask

  task automatic drive(logic [3:0] f, logic [3:0] g, logic [2:0] c,
                       logic [2:0] exp, string req);
    item_t it;
    @(negedge clk_i);
    f_in_i = f; g_in_i = g; c_in_i = c;
    it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic drive_m(logic [3:0] f, logic [3:0] g, logic [2:0] c, string req);
    drive(f, g, c, model(cur_cfg, f, g, c), req);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if ({x_o, y_o, z_o} !== it.exp) begin
          n_fail++;
          $display("FAIL %s: xyz=%b expected %b", it.req, {x_o, y_o, z_o}, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] f5;
    cur_cfg = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: cleared configuration gives all zero
    drive(4'hF, 4'hF, 3'b111, 3'b000, "R1");
    drive(4'h0, 4'h0, 3'b000, 3'b000, "R1");

    // R2 R3 R4 R5 R8: parity F, AND G, majority H, e from c[0]
    load(mk_cfg(16'h6996, 16'h8000, 8'hE8, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0));
    for (int i = 0; i < 16; i++)
      drive_m(4'(i), 4'(15 - i), 3'(i), "R3_R4_R5");
    drive(4'h5, 4'h3, 3'b000, 3'b000, "R2");  // parity(5)=0, AND=0
    drive(4'h7, 4'hF, 3'b001, 3'b111, "R2");  // parity(7)=1, AND=1, maj=1
    load(mk_cfg(16'h6996, 16'h8000, 8'hE8, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2));
    for (int c = 0; c < 8; c++)
      drive_m(4'h1, 4'h0, 3'(c), "R8");

    // R10: toggle serial input with enable low
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      cfg_bit_i = ~cfg_bit_i;
    end
    for (int i = 0; i < 16; i++)
      drive_m(4'(i), 4'hF, 3'b101, "R10");

    // R6 R7: H is parity of its address; every line code
    for (int sa = 0; sa < 4; sa++) begin
      load(mk_cfg(16'hFFFF, 16'h0000, 8'h96, 1'b1, 1'b1, 2'(sa), 2'(3 - sa), 2'(sa)));
      for (int c = 0; c < 8; c++)
        drive_m(4'h0, 4'h0, 3'(c), "R6_R7");
    end
    // R6: fallback code 3 picks c[0] only; a=c0, b=z=0, e=c0 -> y=0
    load(mk_cfg(16'h0000, 16'h0000, 8'h96, 1'b1, 1'b0, 2'd3, 2'd0, 2'd0));
    drive(4'h0, 4'h0, 3'b110, 3'b000, "R6");
    drive(4'h0, 4'h0, 3'b001, 3'b000, "R6");

    // R9: outputs zero while loading
    load(mk_cfg(16'hFFFF, 16'hFFFF, 8'hFF, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0));
    drive(4'h3, 4'h3, 3'b000, 3'b111, "R9");
    @(negedge clk_i);
    prog_en_i = 1'b1;
    cfg_bit_i = 1'b1;
    begin
      item_t it;
      it.exp = 3'b000; it.req = "R9";
      q.push_back(it);
    end
    @(negedge clk_i);
    prog_en_i = 1'b0;

    // R11: 5-input function from two cofactors
    f5 = 32'hCAFE_1234;
    load(mk_cfg(f5[31:16], f5[15:0], 8'hAC, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0));
    for (int i = 0; i < 32; i++) begin
      logic [3:0] a;
      a = 4'(i);
      drive(a, a, {2'b00, i[4]}, {f5[16 + int'(a)], f5[i], f5[int'(a)]}, "R11");
    end

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule